// File: doc/BRIEF.md
# Key-Protected System Control Register Bank

This block is a bank of 32-bit control and status words. A host reaches it over a simple word bus: one request per cycle, with a valid flag, a write flag, a byte address and write data. Read data comes back one cycle later with a valid strobe. The word index is the byte address divided by four. Data words are little-endian, so bit 0 of the bus is bit 0 of byte 0.

A single protection bit lives in word 0, and the host controls it:
- Writing the magic key value to word 0 sets the bit, which unlocks the protected window.
- Writing any other value to word 0 clears the bit.
- While the bit is clear, writes to the window from byte 0x04 up to 0x100 are dropped.
- Words at 0x104 and above stay writable at all times.

Some words are read-only and one word is write-only. Reading the random-data word steps an internal LFSR and returns the new value. Any illegal access raises a one-cycle error pulse. Synchronous reset loads a constant image chosen by a variant parameter. In the same reset, the strap, revision and key-state inputs overwrite their own words.

Top module: `sysctl_keybank`

## Requirements
- R1: The word index is req_addr >> 2. An access with req_addr[1:0] != 0 changes no word, reads back 0 and raises the error pulse.
- R2: A write to byte 0x00 stores 1 when the data equals KEY (default 0x1688A8A8) and stores 0 for any other data. A read of 0x00 returns that 0 or 1 in bit 0, with the upper bits at 0. Writes to 0x00 are never blocked.
- R3: While the key bit is 0, a write to any byte address from 0x04 to 0x100 is discarded and raises the error pulse. Writes at 0x104 and above are stored whatever the key bit holds.
- R4: Writes to 0x14, to 0x50 through 0x6C, and to 0x78, 0x7C, 0xE0 and 0xE4 leave the word unchanged and raise the error pulse.
- R5: Each read of 0x78 advances a 32-bit LFSR one step and returns the new state. The LFSR starts at LFSR_SEED (default 0x2468ACE1). One step is: if bit 0 is 1, the next state is (s >> 1) ^ 0x80200003; otherwise it is s >> 1. The contents of word 0x74 have no influence on this.
- R6: A read of 0xC0 returns the stored word and raises the error pulse. A write to 0xC0 is a normal write.
- R7: Reset loads the image for the chosen VARIANT, then applies the inputs:
  - For VARIANT 0, the image holds 0x24 = 0x00000291, 0x88 = 0x01000000, 0x8C = 0x000000FF, 0x9C = 0x003FFFF3 and 0x74 = 0x0000000E.
  - 0x70 takes strap_a_in.
  - 0xD0 takes strap_b_in.
  - 0x7C takes rev_in.
  - Word 0 takes key_state_in.
- R8: An access whose word index is NUM_WORDS or more (default: byte 0x200 and up) is rejected. It reads back 0 and raises the error pulse.
- R9: A request in cycle N gives rd_valid (reads only), rd_data and access_err in cycle N+1. access_err is high for exactly one cycle per illegal access and is low after a legal access.
- R10: Every other in-range word is read/write over all 32 bits and reads back its own last written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| strap_a_in | input | 32 | Loaded into word 0x70 at reset |
| strap_b_in | input | 32 | Loaded into word 0xD0 at reset |
| rev_in | input | 32 | Loaded into word 0x7C at reset |
| key_state_in | input | 1 | Initial key bit loaded at reset |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data |
| access_err | output | 1 | One-cycle pulse for an illegal access |

## Verification
The key bit is internal state, and a wrong value shows up in two ways:
- A read of word 0 one cycle later returns the wrong bit.
- A write into the window is then kept or dropped when it should not be, which shows in access_err one cycle after the write and in the read-back of that word.

A wrong attribute decode shows as an error pulse that should not appear, or one that is missing, one cycle after the access. A read-only word that was wrongly changed shows at its next read. A wrong LFSR state or step shows at the very next read of 0x78, because every value returned there is the successor of the previous one.

// File: rtl/sysctl_keybank_pkg.sv
// Package: shared constants and the reset image for the key-protected
// register bank. Assumes 32-bit words; word indices are byte offset / 4.
package sysctl_keybank_pkg;

    localparam int DW = 32;

    // Word indices with behaviour attached to them
    localparam int W_KEY       = 'h000 / 4;
    localparam int W_FCNT_EVAL = 'h014 / 4;
    localparam int W_SCR_FIRST = 'h050 / 4;
    localparam int W_SCR_LAST  = 'h06C / 4;
    localparam int W_STRAP_A   = 'h070 / 4;
    localparam int W_RNG       = 'h078 / 4;
    localparam int W_REV       = 'h07C / 4;
    localparam int W_WAKE_EN   = 'h0C0 / 4;
    localparam int W_STRAP_B   = 'h0D0 / 4;
    localparam int W_FREE_LO   = 'h0E0 / 4;
    localparam int W_FREE_HI   = 'h0E4 / 4;
    localparam int W_OPEN_BASE = 'h104 / 4;

    // Galois feedback mask of the random-data LFSR
    localparam logic [DW-1:0] LFSR_MASK = 32'h8020_0003;

    // Constant reset image, per variant, by word index
    function automatic logic [DW-1:0] image_word(input int variant, input int widx);
        logic [DW-1:0] v;
        v = '0;
        case (widx * 4)
            'h1A4: v = 32'h0000_2402;
            'h180: v = 32'h0000_007B;
            'h160: v = 32'h0000_1903;
            'h114: v = 32'hC000_0000;
            'h110: v = 32'h1E60_0000;
            'h104: v = 32'h8000_0000;
            'h0E4: v = 32'h0000_00FF;
            'h0E0: v = 32'h0000_00FF;
            'h0A8: v = 32'h000F_FFFF;
            'h0A4: v = 32'hFFFF_0000;
            'h09C: v = (variant == 0) ? 32'h003F_FFF3 : 32'h023F_FFF3;
            'h090: v = 32'h0000_A000;
            'h08C: v = (variant == 0) ? 32'h0000_00FF : 32'h0000_0000;
            'h088: v = (variant == 0) ? 32'h0100_0000 : 32'h0300_0000;
            'h084: v = 32'h0000_F000;
            'h074: v = 32'h0000_000E;
            'h04C: v = 32'h0000_0023;
            'h040: v = 32'h0000_00C0;
            'h03C: v = 32'h0000_0001;
            'h038: v = 32'h0400_0030;
            'h034: v = 32'h2000_1A03;
            'h030: v = 32'h2000_1A03;
            'h02C: v = 32'h0000_0010;
            'h024: v = (variant == 0) ? 32'h0000_0291 : 32'h9300_0400;
            'h020: v = 32'h0003_0291;
            'h01C: v = 32'h0002_6108;
            'h00C: v = 32'h19FC_3E8B;
            'h008: v = 32'hF3F4_0000;
            'h004: v = 32'hFFCF_FEDC;
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/sysctl_keybank_decode.sv
// Module: address decode and access attributes.
// Purely combinational. Assumes NUM_WORDS <= 2**(ADDR_W-2) and
// NUM_WORDS > W_OPEN_BASE so the protected window lies inside the bank.
module sysctl_keybank_decode
    import sysctl_keybank_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_WORDS = 128,
    localparam int IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic              legal,
    output logic              in_lock_win,
    output logic              is_ro,
    output logic              is_wo,
    output logic              is_rng
);

    logic [ADDR_W-3:0] widx;
    int                wi;

    // Word index and range / alignment check
    always_comb begin
        widx  = addr[ADDR_W-1:2];
        wi    = int'(widx);
        idx   = widx[IDX_W-1:0];
        legal = (addr[1:0] == 2'b00) && (wi < NUM_WORDS);
    end

    // Attribute lookup for the word index
    always_comb begin
        in_lock_win = (wi > W_KEY) && (wi < W_OPEN_BASE);
        is_ro       = (wi == W_FCNT_EVAL)
                   || ((wi >= W_SCR_FIRST) && (wi <= W_SCR_LAST))
                   || (wi == W_RNG) || (wi == W_REV)
                   || (wi == W_FREE_LO) || (wi == W_FREE_HI);
        is_wo       = (wi == W_WAKE_EN);
        is_rng      = (wi == W_RNG);
    end

endmodule

// File: rtl/sysctl_keybank_lfsr.sv
// Module: 32-bit Galois LFSR used as the random-data source.
// Steps once per asserted 'step'; 'next_o' is the state after one step,
// so a reader can capture the fresh word in the same cycle it is made.
// Assumes SEED is nonzero.
module sysctl_keybank_lfsr
    import sysctl_keybank_pkg::*;
#(
    parameter logic [DW-1:0] SEED = 32'h2468_ACE1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [DW-1:0] next_o
);

    logic [DW-1:0] state_q;

    // Successor state of the current value
    always_comb begin
        next_o = state_q[0] ? ((state_q >> 1) ^ LFSR_MASK) : (state_q >> 1);
    end

    // State register: seed at reset, advance on request
    always_ff @(posedge clk) begin
        if (!rst_n)    state_q <= SEED;
        else if (step) state_q <= next_o;
    end

endmodule

// File: rtl/sysctl_keybank_regs.sv
// Module: word storage with per-word reset values.
// Each word loads the variant image at reset, except the strap, revision
// and key words, which load their inputs. One write port, one read port.
module sysctl_keybank_regs
    import sysctl_keybank_pkg::*;
#(
    parameter int NUM_WORDS = 128,
    parameter int VARIANT   = 0,
    localparam int IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic [DW-1:0]    strap_a,
    input  logic [DW-1:0]    strap_b,
    input  logic [DW-1:0]    rev,
    input  logic             key_init,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DW-1:0]    rd_word,
    output logic             key_bit
);

    logic [NUM_WORDS-1:0][DW-1:0] words;

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        logic [DW-1:0] init_val;
        logic [DW-1:0] word_q;

        // Reset source for this word
        if (i == W_KEY) begin : g_key
            assign init_val = {{(DW-1){1'b0}}, key_init};
        end else if (i == W_STRAP_A) begin : g_sa
            assign init_val = strap_a;
        end else if (i == W_STRAP_B) begin : g_sb
            assign init_val = strap_b;
        end else if (i == W_REV) begin : g_rev
            assign init_val = rev;
        end else begin : g_img
            assign init_val = image_word(VARIANT, i);
        end

        // Word register: reset load or addressed write
        always_ff @(posedge clk) begin
            if (!rst_n)                              word_q <= init_val;
            else if (wr_en && (wr_idx == IDX_W'(i))) word_q <= wr_data;
        end

        assign words[i] = word_q;
    end

    // Read port and key bit tap
    always_comb begin
        rd_word = words[rd_idx];
        key_bit = words[W_KEY][0];
    end

endmodule

// File: rtl/sysctl_keybank.sv
// Module: key-protected control register bank (top).
// Applies the lock, access attributes and random-data read on top of the
// word storage. Registers read data and the error pulse one cycle after
// the request. Assumes single-cycle requests with no back-pressure.
module sysctl_keybank
    import sysctl_keybank_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter int          NUM_WORDS = 128,
    parameter int          VARIANT   = 0,
    parameter logic [31:0] KEY       = 32'h1688_A8A8,
    parameter logic [31:0] LFSR_SEED = 32'h2468_ACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [31:0]       strap_a_in,
    input  logic [31:0]       strap_b_in,
    input  logic [31:0]       rev_in,
    input  logic              key_state_in,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic              access_err
);

    localparam int IDX_W = $clog2(NUM_WORDS);

    logic [IDX_W-1:0] idx;
    logic             legal, in_lock_win, is_ro, is_wo, is_rng;
    logic             key_state;
    logic [DW-1:0]    rd_word, rng_next, wr_data, rd_next;
    logic             wr_req, rd_req, lock_block, wr_en, rng_step, err_next;

    sysctl_keybank_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_WORDS(NUM_WORDS)
    ) u_decode (
        .addr       (req_addr),
        .idx        (idx),
        .legal      (legal),
        .in_lock_win(in_lock_win),
        .is_ro      (is_ro),
        .is_wo      (is_wo),
        .is_rng     (is_rng)
    );

    // Access qualification: lock, read-only and error conditions
    always_comb begin
        wr_req     = req_valid && req_write;
        rd_req     = req_valid && !req_write;
        lock_block = in_lock_win && !key_state;
        wr_en      = wr_req && legal && !lock_block && !is_ro;
        rng_step   = rd_req && legal && is_rng;
        wr_data    = (idx == IDX_W'(W_KEY)) ? {{(DW-1){1'b0}}, (req_wdata == KEY)}
                                            : req_wdata;
        err_next   = req_valid && (!legal
                   || (req_write && (lock_block || is_ro))
                   || (!req_write && is_wo));
    end

    sysctl_keybank_regs #(
        .NUM_WORDS(NUM_WORDS),
        .VARIANT  (VARIANT)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (idx),
        .wr_data (wr_data),
        .strap_a (strap_a_in),
        .strap_b (strap_b_in),
        .rev     (rev_in),
        .key_init(key_state_in),
        .rd_idx  (idx),
        .rd_word (rd_word),
        .key_bit (key_state)
    );

    sysctl_keybank_lfsr #(
        .SEED(LFSR_SEED)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (rng_step),
        .next_o(rng_next)
    );

    // Read data select: rejected access reads 0, random word reads fresh value
    always_comb begin
        if (!legal)      rd_next = '0;
        else if (is_rng) rd_next = rng_next;
        else             rd_next = rd_word;
    end

    // Response registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid   <= 1'b0;
            rd_data    <= '0;
            access_err <= 1'b0;
        end else begin
            rd_valid   <= rd_req;
            rd_data    <= rd_req ? rd_next : '0;
            access_err <= err_next;
        end
    end

endmodule

// File: rtl/sysctl_keybank_chk.sv
// Module: assertion checker for sysctl_keybank, attached by bind.
// Watches the request ports, the response ports and the internal key bit.
module sysctl_keybank_chk #(
    parameter int ADDR_W    = 12,
    parameter int NUM_WORDS = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rd_valid,
    input logic [31:0]       rd_data,
    input logic              access_err,
    input logic              key_state
);

    p_misalign_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[1:0] != 2'b00) |=> access_err);

    p_key_bool_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == '0) |=> (rd_data[31:1] == '0));

    p_lock_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !key_state && req_addr[1:0] == 2'b00
         && req_addr != '0 && req_addr < ADDR_W'('h104)) |=> access_err);

    p_rng_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == ADDR_W'('h78)) |=> (rd_data != '0));

    p_oor_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && int'(req_addr[ADDR_W-1:2]) >= NUM_WORDS)
        |=> (access_err && rd_data == '0));

    p_read_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);

    p_write_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> !rd_valid);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!access_err && !rd_valid));

endmodule

bind sysctl_keybank sysctl_keybank_chk #(
    .ADDR_W   (ADDR_W),
    .NUM_WORDS(NUM_WORDS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .access_err(access_err),
    .key_state (key_state)
);

// File: tb/sysctl_keybank_bench.sv
module sysctl_keybank_bench;

    localparam logic [31:0] KEY   = 32'h1688_A8A8;
    localparam logic [31:0] SEED  = 32'h2468_ACE1;
    localparam logic [31:0] SA    = 32'hA5A5_0123;
    localparam logic [31:0] SB    = 32'h0F0F_7788;
    localparam logic [31:0] REV   = 32'h0201_0303;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        access_err;

    int checks = 0;
    int fails  = 0;
    logic [31:0] rng_model = SEED;

    always #5 clk = ~clk;

    sysctl_keybank u_sysctl_keybank (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .strap_a_in  (SA),
        .strap_b_in  (SB),
        .rev_in      (REV),
        .key_state_in(1'b0),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .access_err  (access_err)
    );

    function automatic logic [31:0] lfsr_step(input logic [31:0] s);
        return s[0] ? ((s >> 1) ^ 32'h8020_0003) : (s >> 1);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One request; results of the registered response sampled at the next negedge
    task automatic do_write(input logic [11:0] a, input logic [31:0] d, output logic err);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        err = access_err;
    endtask

    task automatic do_read(input logic [11:0] a, output logic [31:0] d, output logic err);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rd_data; err = access_err;
        check("R9 rd_valid", {31'b0, rd_valid}, 32'd1);
    endtask

    task automatic t_reset;
        logic [31:0] d; logic e;
        do_read(12'h000, d, e); check("R7 key from input", d, 32'd0);
        check("R9 no err on legal read", {31'b0, e}, 32'd0);
        do_read(12'h070, d, e); check("R7 strap A", d, SA);
        do_read(12'h0D0, d, e); check("R7 strap B", d, SB);
        do_read(12'h07C, d, e); check("R7 revision", d, REV);
        do_read(12'h024, d, e); check("R7 image 0x24", d, 32'h0000_0291);
        do_read(12'h09C, d, e); check("R7 image 0x9C", d, 32'h003F_FFF3);
        do_read(12'h088, d, e); check("R7 image 0x88", d, 32'h0100_0000);
        do_read(12'h08C, d, e); check("R7 image 0x8C", d, 32'h0000_00FF);
        do_read(12'h074, d, e); check("R7 image 0x74", d, 32'h0000_000E);
    endtask

    task automatic t_locked;
        logic [31:0] d; logic e;
        do_write(12'h048, 32'hDEAD_BEEF, e); check("R3 locked write err", {31'b0, e}, 32'd1);
        do_read(12'h048, d, e);              check("R3 locked write dropped", d, 32'd0);
        do_write(12'h100, 32'h1234_5678, e); check("R3 window top err", {31'b0, e}, 32'd1);
        do_read(12'h100, d, e);              check("R3 window top dropped", d, 32'd0);
        do_write(12'h104, 32'h5555_AAAA, e); check("R3 open write no err", {31'b0, e}, 32'd0);
        do_read(12'h104, d, e);              check("R3 open write stored", d, 32'h5555_AAAA);
    endtask

    task automatic t_key;
        logic [31:0] d; logic e;
        do_write(12'h000, KEY ^ 32'h1, e); check("R2 key write never blocked", {31'b0, e}, 32'd0);
        do_read(12'h000, d, e);            check("R2 wrong key reads 0", d, 32'd0);
        do_write(12'h000, KEY, e);
        do_read(12'h000, d, e);            check("R2 key reads 1", d, 32'd1);
        do_write(12'h048, 32'hCAFE_F00D, e); check("R10 unlocked write no err", {31'b0, e}, 32'd0);
        do_read(12'h048, d, e);              check("R10 readback", d, 32'hCAFE_F00D);
        do_write(12'h1A0, 32'h0BAD_CAFE, e);
        do_read(12'h1A0, d, e);              check("R1 word 0x1A0", d, 32'h0BAD_CAFE);
        do_read(12'h1A4, d, e);              check("R1 neighbour 0x1A4 intact", d, 32'h0000_2402);
    endtask

    task automatic t_readonly;
        logic [31:0] d; logic e;
        do_write(12'h014, 32'hFFFF_FFFF, e); check("R4 0x14 err", {31'b0, e}, 32'd1);
        do_read(12'h014, d, e);              check("R4 0x14 unchanged", d, 32'd0);
        do_write(12'h050, 32'h1111_1111, e); check("R4 0x50 err", {31'b0, e}, 32'd1);
        do_read(12'h050, d, e);              check("R4 0x50 unchanged", d, 32'd0);
        do_write(12'h06C, 32'h2222_2222, e);
        do_read(12'h06C, d, e);              check("R4 0x6C unchanged", d, 32'd0);
        do_write(12'h07C, 32'h3333_3333, e); check("R4 0x7C err", {31'b0, e}, 32'd1);
        do_read(12'h07C, d, e);              check("R4 0x7C unchanged", d, REV);
        do_write(12'h0E4, 32'h0, e);
        do_read(12'h0E4, d, e);              check("R4 0xE4 unchanged", d, 32'h0000_00FF);
        do_write(12'h078, 32'h0, e);         check("R4 0x78 err", {31'b0, e}, 32'd1);
    endtask

    task automatic t_rng;
        logic [31:0] d; logic e;
        for (int k = 0; k < 3; k++) begin
            rng_model = lfsr_step(rng_model);
            do_read(12'h078, d, e); check("R5 random word", d, rng_model);
        end
        do_write(12'h074, 32'h0, e);
        rng_model = lfsr_step(rng_model);
        do_read(12'h078, d, e); check("R5 random word with control 0", d, rng_model);
    endtask

    task automatic t_writeonly;
        logic [31:0] d; logic e;
        do_write(12'h0C0, 32'h0000_00A5, e); check("R6 write to 0xC0 legal", {31'b0, e}, 32'd0);
        do_read(12'h0C0, d, e);
        check("R6 read returns value", d, 32'h0000_00A5);
        check("R6 read flags err", {31'b0, e}, 32'd1);
        @(negedge clk);
        check("R9 err one cycle only", {31'b0, access_err}, 32'd0);
    endtask

    task automatic t_range_align;
        logic [31:0] d; logic e;
        do_read(12'h200, d, e);
        check("R8 out of range read 0", d, 32'd0);
        check("R8 out of range err", {31'b0, e}, 32'd1);
        do_write(12'hFFC, 32'h1, e); check("R8 out of range write err", {31'b0, e}, 32'd1);
        do_read(12'h072, d, e);
        check("R1 misaligned read 0", d, 32'd0);
        check("R1 misaligned read err", {31'b0, e}, 32'd1);
        do_write(12'h049, 32'h7777_7777, e); check("R1 misaligned write err", {31'b0, e}, 32'd1);
        do_read(12'h048, d, e);              check("R1 misaligned write dropped", d, 32'hCAFE_F00D);
        check("R9 err low after legal read", {31'b0, e}, 32'd0);
    endtask

    task automatic t_relock;
        logic [31:0] d; logic e;
        do_write(12'h000, 32'h0, e);
        do_read(12'h000, d, e);              check("R2 relock reads 0", d, 32'd0);
        do_write(12'h048, 32'h0, e);         check("R3 relocked write err", {31'b0, e}, 32'd1);
        do_read(12'h048, d, e);              check("R3 relocked word kept", d, 32'hCAFE_F00D);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R9 rd_valid in reset", {31'b0, rd_valid}, 32'd0);
        check("R9 err in reset", {31'b0, access_err}, 32'd0);
        rst_n = 1'b1;
        t_reset;
        t_locked;
        t_key;
        t_readonly;
        t_rng;
        t_writeonly;
        t_range_align;
        t_relock;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule